// File: doc/BRIEF.md
# Spread-Spectrum Clock Dither Generator

This block produces a small signed offset that moves an oscillator trim word back and forth in a pseudo-random pattern. Spreading the oscillator frequency this way lowers the spectral peaks of the clock. The random source is an 8-bit maximum-length shift register. It advances once per rising edge of a slow reference clock of 32.768 kHz, which the block samples in its own fast clock domain. A two-bit width setting chooses how many low bits of the register state form the offset: 4, 5, 6 or 7 bits. The chosen field is shifted down by half its range, so the offset is centred on zero. Each step of the setting therefore doubles the spread bandwidth. A separate enable turns spreading off, which gives five settings in all.

The offset is held in a register and changes only on a reference edge. Both enable and width are taken at that edge, so a setting that changes between edges never disturbs the output. The block also adds the offset to an incoming unsigned trim word. The sum is clamped to the legal trim range and sent out as the trim word the oscillator uses. The current shift-register state is also an output.

Top module: `ditherSpread`

## Requirements
- R1: After reset the shift-register state is 8'h01, the offset is 0, and the output trim equals the input trim.
- R2: On each rising edge of the reference clock the state advances exactly once: it shifts left by one, and the new bit 0 is the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1). Between reference edges the state does not move.
- R3: The state is never 8'h00. Starting from reset, it runs through all 255 nonzero values, each exactly once, and returns to 8'h01 after 255 reference edges.
- R4: With the enable low at a reference edge, the offset becomes 0 whatever the width setting is, and the output trim equals the input trim.
- R5: With the enable high, width codes 0, 1, 2 and 3 select N = 4, 5, 6 and 7 low bits of the new state. The offset is those N bits read as unsigned, minus 2^(N-1), driven as an 8-bit two's-complement value.
- R6: Over one full period with a fixed width code, the offset reaches exactly -2^(N-1) at its lowest and 2^(N-1)-1 at its highest, so the span doubles with each code step.
- R7: Over one full period with a fixed width code, the offsets sum to 2^(N-1)-128. This keeps the average within half an LSB of zero.
- R8: Enable and width are taken only at a reference edge. Changing them between edges leaves the offset and the state unchanged until the next edge, and that edge applies the new setting.
- R9: The output trim is the input trim plus the sign-extended offset, clamped to the range 0 to 2^TRIM_W-1 (0 to 8191 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refClk | input | 1 | 32.768 kHz reference level, sampled in the clk domain |
| spreadEn | input | 1 | Spreading enable, taken at a reference edge |
| spreadCfg | input | 2 | Width code 0..3, which selects 4..7 bits |
| trimIn | input | TRIM_W | Unsigned oscillator trim before dithering |
| ditherOut | output | 8 | Signed dither offset, two's complement |
| trimOut | output | TRIM_W | Dithered trim, clamped |
| lfsrState | output | 8 | Current shift-register state |

## Verification
The hardest properties to reach from the ports are the whole-period ones: all 255 states visited with no repeat, the exact extremes, and the exact period sum. Each can only be judged after hundreds of reference edges with no change of setting. The bench therefore drives full 255-edge periods for every width code. It records each state and accumulates the offsets, and it runs these periods alongside a scoreboard that predicts every single step. Saturation is reached by pinning the trim input at 0 and at full scale under the widest setting. Setting changes between edges are made while the reference level is held low.

// File: rtl/ditherPkg.sv
package ditherPkg;
  localparam int LFSR_W = 8;
  localparam int WIDTH_CODES = 4;

  typedef struct packed {
    logic       step;
    logic       en;
    logic [1:0] width;
  } ditherStrobe_t;
endpackage

// File: rtl/ditherCtrl.sv
module ditherCtrl
  import ditherPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          refClk,
  input  logic          spreadEn,
  input  logic [1:0]    spreadCfg,
  output ditherStrobe_t stb
);
  logic refMeta, refSync, refPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refMeta <= 1'b0;
      refSync <= 1'b0;
      refPrev <= 1'b0;
    end else begin
      refMeta <= refClk;
      refSync <= refMeta;
      refPrev <= refSync;
    end
  end

  always_comb begin
    stb.step  = refSync & ~refPrev;
    stb.en    = spreadEn;
    stb.width = spreadCfg;
  end

  // one advance per reference edge
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> !stb.step);
endmodule

// File: rtl/ditherPath.sv
module ditherPath
  import ditherPkg::*;
#(
  parameter int               TRIM_W   = 13,
  parameter int               MIN_BITS = 4,
  parameter logic [LFSR_W-1:0] SEED    = 8'h01
)(
  input  logic              clk,
  input  logic              rstN,
  input  ditherStrobe_t     stb,
  input  logic [TRIM_W-1:0] trimIn,
  output logic [LFSR_W-1:0] ditherOut,
  output logic [TRIM_W-1:0] trimOut,
  output logic [LFSR_W-1:0] lfsrState
);
  localparam int SUM_W = TRIM_W + 2;
  localparam logic signed [SUM_W-1:0] TRIM_MAX = SUM_W'((1 << TRIM_W) - 1);

  logic [LFSR_W-1:0] lfsrQ, nextState, ditherQ, ditherD;
  logic [LFSR_W:0]   cand [WIDTH_CODES];

  always_comb nextState = {lfsrQ[LFSR_W-2:0], lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3]};

  for (genvar g = 0; g < WIDTH_CODES; g++) begin : gWin
    localparam int N = MIN_BITS + g;
    localparam logic [LFSR_W:0] MASK = (LFSR_W+1)'((1 << N) - 1);
    localparam logic [LFSR_W:0] HALF = (LFSR_W+1)'(1 << (N - 1));
    assign cand[g] = ({1'b0, nextState} & MASK) - HALF;
  end

  always_comb ditherD = stb.en ? cand[stb.width][LFSR_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ   <= SEED;
      ditherQ <= '0;
    end else if (stb.step) begin
      lfsrQ   <= nextState;
      ditherQ <= ditherD;
    end
  end

  logic signed [SUM_W-1:0] sumS;
  always_comb begin
    sumS = $signed({2'b00, trimIn}) + $signed({{(SUM_W-LFSR_W){ditherQ[LFSR_W-1]}}, ditherQ});
    if (sumS < 0)             trimOut = '0;
    else if (sumS > TRIM_MAX) trimOut = '1;
    else                      trimOut = sumS[TRIM_W-1:0];
  end

  assign ditherOut = ditherQ;
  assign lfsrState = lfsrQ;

  assert_never_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.step |=> ($stable(lfsrQ) && $stable(ditherQ)));
  assert_off_is_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.en) |=> (ditherOut == '0));
  assert_window_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && stb.en) |=>
      (int'($signed(ditherOut)) >= -(1 << (MIN_BITS + int'($past(stb.width)) - 1)) &&
       int'($signed(ditherOut)) <  (1 << (MIN_BITS + int'($past(stb.width)) - 1))));
  assert_trim_up_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ditherOut[LFSR_W-1] |-> (trimOut >= trimIn));
  assert_trim_down_R9: assert property (@(posedge clk) disable iff (!rstN)
    ditherOut[LFSR_W-1] |-> (trimOut <= trimIn));
endmodule

// File: rtl/ditherSpread.sv
module ditherSpread
  import ditherPkg::*;
#(
  parameter int TRIM_W   = 13,
  parameter int MIN_BITS = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              refClk,
  input  logic              spreadEn,
  input  logic [1:0]        spreadCfg,
  input  logic [TRIM_W-1:0] trimIn,
  output logic [7:0]        ditherOut,
  output logic [TRIM_W-1:0] trimOut,
  output logic [7:0]        lfsrState
);
  ditherStrobe_t stb;

  ditherCtrl uCtrl (
    .clk(clk), .rstN(rstN), .refClk(refClk),
    .spreadEn(spreadEn), .spreadCfg(spreadCfg), .stb(stb)
  );

  ditherPath #(.TRIM_W(TRIM_W), .MIN_BITS(MIN_BITS), .SEED(8'h01)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .trimIn(trimIn),
    .ditherOut(ditherOut), .trimOut(trimOut), .lfsrState(lfsrState)
  );
endmodule

// File: tb/sim_ditherSpread.sv
module sim_ditherSpread;
  localparam int TRIM_W = 13;
  localparam int TMAX = (1 << TRIM_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refClk = 1'b0;
  logic spreadEn = 1'b0;
  logic [1:0] spreadCfg = 2'd0;
  logic [TRIM_W-1:0] trimIn = '0;
  logic [7:0] ditherOut, lfsrState;
  logic [TRIM_W-1:0] trimOut;

  always #2.5 clk = ~clk;

  ditherSpread #(.TRIM_W(TRIM_W)) u0 (
    .clk(clk), .rstN(rstN), .refClk(refClk), .spreadEn(spreadEn),
    .spreadCfg(spreadCfg), .trimIn(trimIn), .ditherOut(ditherOut),
    .trimOut(trimOut), .lfsrState(lfsrState)
  );

  typedef struct {
    logic [7:0] st;
    int dith;
    int trim;
  } expItem_t;

  expItem_t sbq[$];
  int errors = 0;
  int checks = 0;
  logic [7:0] model = 8'h01;
  bit monOn = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] modelStep(logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // driver: predicts one step, then produces one reference edge
  task automatic refEdge(bit en, logic [1:0] cfg, int trim);
    expItem_t it;
    int n, d, t;
    model = modelStep(model);
    n = 4 + int'(cfg);
    d = en ? (int'(model) & ((1 << n) - 1)) - (1 << (n - 1)) : 0;
    t = trim + d;
    if (t < 0) t = 0;
    if (t > TMAX) t = TMAX;
    it.st = model; it.dith = d; it.trim = t;
    sbq.push_back(it);
    @(negedge clk);
    spreadEn = en; spreadCfg = cfg; trimIn = TRIM_W'(trim); refClk = 1'b1;
    repeat (6) @(negedge clk);
    refClk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // monitor: every state change must match the next predicted item
  initial begin
    wait (monOn);
    forever begin
      expItem_t it;
      @(lfsrState);
      @(negedge clk);
      if (sbq.size() == 0) begin
        check(0, "R2", "unexpected advance", int'(lfsrState), -1);
      end else begin
        it = sbq.pop_front();
        check(lfsrState == it.st, "R2", "state", int'(lfsrState), int'(it.st));
        check(int'($signed(ditherOut)) == it.dith, "R5", "offset", int'($signed(ditherOut)), it.dith);
        check(int'(trimOut) == it.trim, "R9", "trim", int'(trimOut), it.trim);
      end
    end
  end

  task automatic fullPeriod(logic [1:0] cfg, bit trackVisits);
    bit seen [256];
    int sum, mn, mx, dups, n;
    sum = 0; mn = 1000; mx = -1000; dups = 0;
    n = 4 + int'(cfg);
    for (int i = 0; i < 256; i++) seen[i] = 0;
    for (int i = 0; i < 255; i++) begin
      int d;
      refEdge(1'b1, cfg, 4000);
      d = int'($signed(ditherOut));
      sum += d;
      if (d < mn) mn = d;
      if (d > mx) mx = d;
      if (seen[lfsrState] || lfsrState == 8'h00) dups++;
      seen[lfsrState] = 1;
    end
    if (trackVisits) begin
      check(dups == 0, "R3", "repeated or zero states", dups, 0);
      check(lfsrState == 8'h01, "R3", "state after 255 edges", int'(lfsrState), 1);
    end
    check(mn == -(1 << (n - 1)), "R6", "period minimum", mn, -(1 << (n - 1)));
    check(mx == (1 << (n - 1)) - 1, "R6", "period maximum", mx, (1 << (n - 1)) - 1);
    check(sum == (1 << (n - 1)) - 128, "R7", "period sum", sum, (1 << (n - 1)) - 128);
  endtask

  initial begin
    trimIn = TRIM_W'(1234);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(lfsrState == 8'h01, "R1", "reset state", int'(lfsrState), 1);
    check(ditherOut == 8'h00, "R1", "reset offset", int'(ditherOut), 0);
    check(trimOut == trimIn, "R1", "reset trim", int'(trimOut), int'(trimIn));
    monOn = 1;

    // R3 R6 R7 from reset with width code 0
    fullPeriod(2'd0, 1'b1);
    fullPeriod(2'd1, 1'b0);
    fullPeriod(2'd2, 1'b0);
    fullPeriod(2'd3, 1'b0);

    // R4: disabled with widest code
    for (int i = 0; i < 4; i++) begin
      refEdge(1'b0, 2'd3, 2500);
      check(ditherOut == 8'h00, "R4", "offset when off", int'(ditherOut), 0);
      check(trimOut == trimIn, "R4", "trim when off", int'(trimOut), int'(trimIn));
    end

    // R8: setting changes between edges have no effect
    refEdge(1'b1, 2'd0, 4000);
    begin
      logic [7:0] holdD, holdS;
      holdD = ditherOut; holdS = lfsrState;
      spreadCfg = 2'd3; spreadEn = 1'b0;
      repeat (12) @(negedge clk);
      check(ditherOut == holdD, "R8", "offset held", int'(ditherOut), int'(holdD));
      check(lfsrState == holdS, "R8", "state held", int'(lfsrState), int'(holdS));
      spreadEn = 1'b1;
      repeat (12) @(negedge clk);
      check(ditherOut == holdD, "R8", "offset held after enable", int'(ditherOut), int'(holdD));
    end
    refEdge(1'b1, 2'd3, 4000);

    // R9: clamping at both ends
    for (int i = 0; i < 12; i++) refEdge(1'b1, 2'd3, 0);
    for (int i = 0; i < 12; i++) refEdge(1'b1, 2'd3, TMAX);
    for (int i = 0; i < 6; i++) refEdge(1'b1, 2'd2, 40);

    repeat (10) @(negedge clk);
    check(sbq.size() == 0, "R2", "pending predictions", sbq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule